// File: doc/BRIEF.md
# Weighted Pseudo-Random Test Pattern Source

This block feeds self-test stimulus to a logic block whose inputs need biased values. An unbiased shift-register source gives every bit a one-probability of one half. A wide AND cone then almost never sees all of its inputs high: for eight inputs the chance is 1/256. Here each output bit has its own weight. The weight comes from ANDing between one and four distinct bits of an internal 16-bit maximal-length LFSR, which gives 1/2, 1/4, 1/8 or 1/16. An optional complement turns these into 1/2, 3/4, 7/8 or 15/16.

The weights sit in a small table that holds several complete weight sets, one entry per output bit in each set. A select input picks the set that shapes the next pattern. The table is written through an address/data port while the generator is idle. A seed port loads the shift register before a run. While the enable is high, a new pattern is produced on every clock.

Top module: `wpg_top`

## Requirements
- R1: The shift register is 16 bits wide. On each advance it moves to {s[14:0], s[15]^s[13]^s[12]^s[10]}, where s is the current state. It advances once per clock while `enIn` is high and `seedLoad` is low, and its state is never zero.
- R2: When `seedLoad` is high, the register takes `seedIn`. A zero seed is replaced by 0x0001. A load takes priority over `enIn`: in a load cycle the register does not advance and `patOut` keeps its value.
- R3: A weight entry is 3 bits wide. Bits [1:0] hold a depth c from 0 to 3. Output bit i is the AND of the c+1 bits at positions (i + 4*j) mod 16, for j = 0..c, of the newly advanced register state.
- R4: Bit [2] of a weight entry complements the AND result of R3.
- R5: `patOut` changes only at an edge where the register advances. That pattern uses the weight set that `setSel` names at that same edge. With `enIn` low, `patOut` holds.
- R6: A table write places `wrData` at the set given by `wrAddr[4:3]` and the output given by `wrAddr[2:0]`. The write is accepted only while `enIn` is low. A write attempted while `enIn` is high is dropped.
- R7: After reset, the register holds 0xACE1, `patOut` is all zeros, and every table entry is 0 (a single unweighted bit).
- R8: Over 2048 patterns, an entry of depth 3 without complement gives a one-count between 64 and 200. With the complement, the one-count lies between 1840 and 1990.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enIn | input | 1 | Produce one pattern per clock |
| seedLoad | input | 1 | Load the shift register from seedIn |
| seedIn | input | 16 | Seed value |
| setSel | input | 2 | Weight set for the next pattern |
| wrEn | input | 1 | Weight table write strobe |
| wrAddr | input | 5 | Table address {set, output} |
| wrData | input | 3 | Weight entry {complement, depth} |
| patOut | output | 8 | Weighted pattern |

## Verification
Two pairs of functions can fall in the same cycle. A seed load can meet an advance request, and a table write can meet an enabled run. The stimulus table raises `enIn` together with `seedLoad`, and later together with `wrEn`. In the first case the bench checks that `patOut` holds and that the following patterns start from the loaded seed. In the second case the bench checks that the next patterns of the targeted set still show the entry's old weight.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef struct packed {
    logic advance;
    logic loadSeed;
    logic tblWrite;
  } wpgStrobes_t;

  typedef struct packed {
    logic       invert;
    logic [1:0] depth;
  } wpgWeight_t;
endpackage

// File: rtl/wpg_ctrl.sv
module wpg_ctrl
  import wpg_pkg::*;
(
  input  logic        enIn,
  input  logic        seedLoad,
  input  logic        wrEn,
  output wpgStrobes_t strobes
);
  // A seed load beats an advance; the table is writable only while idle.
  always_comb begin
    strobes.loadSeed = seedLoad;
    strobes.advance  = enIn & ~seedLoad;
    strobes.tblWrite = wrEn & ~enIn;
  end
endmodule

// File: rtl/wpg_weight_table.sv
module wpg_weight_table
  import wpg_pkg::*;
#(
  parameter int NUM_OUT  = 8,
  parameter int NUM_SETS = 4,
  localparam int OUT_W   = $clog2(NUM_OUT),
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int ADDR_W  = OUT_W + SET_W,
  localparam int DEPTH   = NUM_SETS * NUM_OUT
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrStrobe,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  wpgWeight_t               wrData,
  input  logic [SET_W-1:0]         setSel,
  output wpgWeight_t [NUM_OUT-1:0] rowOut
);
  wpgWeight_t mem [DEPTH];
  logic [DEPTH*3-1:0] memFlat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wrStrobe) begin
      mem[wrAddr] <= wrData;
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_read
    assign rowOut[i] = mem[{setSel, OUT_W'(i)}];
  end

  always_comb begin
    for (int k = 0; k < DEPTH; k++) memFlat[k*3 +: 3] = mem[k];
  end

  // R6: entries only change when a write is let through
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |=> $stable(memFlat));
endmodule

// File: rtl/wpg_datapath.sv
module wpg_datapath
  import wpg_pkg::*;
#(
  parameter int              NUM_OUT      = 8,
  parameter int              NUM_SETS     = 4,
  parameter int              LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK   = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED_DEFAULT = 16'hACE1,
  localparam int OUT_W  = $clog2(NUM_OUT),
  localparam int SET_W  = $clog2(NUM_SETS),
  localparam int ADDR_W = OUT_W + SET_W,
  localparam int STRIDE = LFSR_W / 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  wpgStrobes_t        strobes,
  input  logic [LFSR_W-1:0]  seedIn,
  input  logic [SET_W-1:0]   setSel,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  wpgWeight_t         wrData,
  output logic [NUM_OUT-1:0] patOut
);
  logic [LFSR_W-1:0]  lfsrQ;
  logic [LFSR_W-1:0]  lfsrNext;
  logic [NUM_OUT-1:0] shaped;
  wpgWeight_t [NUM_OUT-1:0] row;

  wpg_weight_table #(.NUM_OUT(NUM_OUT), .NUM_SETS(NUM_SETS)) u_table (
    .clk(clk), .rstN(rstN), .wrStrobe(strobes.tblWrite),
    .wrAddr(wrAddr), .wrData(wrData), .setSel(setSel), .rowOut(row)
  );

  assign lfsrNext = {lfsrQ[LFSR_W-2:0], ^(lfsrQ & TAP_MASK)};

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    logic [3:0] picks;
    logic prod;
    for (genvar j = 0; j < 4; j++) begin : g_pick
      localparam int POS = (i + STRIDE * j) % LFSR_W;
      assign picks[j] = lfsrNext[POS];
    end
    always_comb begin
      prod = picks[0];
      if (row[i].depth >= 2'd1) prod = prod & picks[1];
      if (row[i].depth >= 2'd2) prod = prod & picks[2];
      if (row[i].depth == 2'd3) prod = prod & picks[3];
    end
    assign shaped[i] = prod ^ row[i].invert;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ  <= SEED_DEFAULT;
      patOut <= '0;
    end else if (strobes.loadSeed) begin
      lfsrQ <= (seedIn == '0) ? LFSR_W'(1) : seedIn;
    end else if (strobes.advance) begin
      lfsrQ  <= lfsrNext;
      patOut <= shaped;
    end
  end

  // R1: the register never locks at zero
  a_r1_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);
  // R1: one shift step per advance
  a_r1_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> lfsrQ == {$past(lfsrQ[LFSR_W-2:0]), ^($past(lfsrQ) & TAP_MASK)});
  // R2: seed load with zero substitution
  a_r2_seed_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSeed |=> lfsrQ == (($past(seedIn) == '0) ? LFSR_W'(1) : $past(seedIn)));
  // R5: pattern holds when nothing advances
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> $stable(patOut));
endmodule

// File: rtl/wpg_top.sv
module wpg_top
  import wpg_pkg::*;
#(
  parameter int NUM_OUT  = 8,
  parameter int NUM_SETS = 4,
  parameter int LFSR_W   = 16,
  localparam int OUT_W   = $clog2(NUM_OUT),
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int ADDR_W  = OUT_W + SET_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enIn,
  input  logic               seedLoad,
  input  logic [LFSR_W-1:0]  seedIn,
  input  logic [SET_W-1:0]   setSel,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [2:0]         wrData,
  output logic [NUM_OUT-1:0] patOut
);
  wpgStrobes_t strobes;

  wpg_ctrl u_ctrl (
    .enIn(enIn), .seedLoad(seedLoad), .wrEn(wrEn), .strobes(strobes)
  );

  wpg_datapath #(.NUM_OUT(NUM_OUT), .NUM_SETS(NUM_SETS), .LFSR_W(LFSR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .seedIn(seedIn),
    .setSel(setSel), .wrAddr(wrAddr), .wrData(wpgWeight_t'(wrData)),
    .patOut(patOut)
  );
endmodule

// File: tb/wpg_top_test.sv
module wpg_top_test;
  logic clk = 0, rstN = 0, enIn = 0, seedLoad = 0, wrEn = 0;
  logic [15:0] seedIn = '0;
  logic [1:0]  setSel = '0;
  logic [4:0]  wrAddr = '0;
  logic [2:0]  wrData = '0;
  logic [7:0]  patOut;

  int checks = 0, fails = 0;
  bit done = 0;

  wpg_top uut (.*);

  always #4 clk = ~clk;

  // model state
  logic [15:0] mLfsr;
  logic [2:0]  mTbl [32];
  logic [7:0]  mPat;

  function automatic logic [15:0] stepF(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [7:0] shapeF(input logic [15:0] s, input logic [1:0] set);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [2:0] e;
      logic p;
      e = mTbl[{set, 3'(i)}];
      p = s[i];
      for (int j = 1; j < 4; j++) if (j <= int'(e[1:0])) p = p & s[(i + 4*j) % 16];
      r[i] = p ^ e[2];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: patOut=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic ld, input logic [15:0] sd,
                     input logic [1:0] sel, input logic wr, input logic [4:0] ad,
                     input logic [2:0] dt);
    enIn = en; seedLoad = ld; seedIn = sd; setSel = sel;
    wrEn = wr; wrAddr = ad; wrData = dt;
    if (ld) mLfsr = (sd == 0) ? 16'h0001 : sd;
    else if (en) begin mLfsr = stepF(mLfsr); mPat = shapeF(mLfsr, sel); end
    if (wr && !en) mTbl[ad] = dt;
    @(posedge clk);
    @(negedge clk);
  endtask

  // {en, ld, seed, sel, wr, addr, data}
  typedef struct packed {
    logic en; logic ld; logic [15:0] sd; logic [1:0] sel;
    logic wr; logic [4:0] ad; logic [2:0] dt;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 16'h0000, 2'd0, 1'b1, 5'b01_000, 3'b011}, // R6 set1 out0 depth3
    '{1'b0, 1'b0, 16'h0000, 2'd0, 1'b1, 5'b01_001, 3'b111}, // R4 set1 out1 15/16
    '{1'b0, 1'b0, 16'h0000, 2'd0, 1'b1, 5'b01_010, 3'b100}, // R4 complemented single
    '{1'b0, 1'b0, 16'h0000, 2'd0, 1'b1, 5'b01_011, 3'b001}, // R3 depth1
    '{1'b0, 1'b0, 16'h0000, 2'd0, 1'b1, 5'b10_111, 3'b110}, // R3 set2 out7
    '{1'b1, 1'b0, 16'h0000, 2'd0, 1'b0, 5'b00_000, 3'b000}, // R5 set0
    '{1'b1, 1'b0, 16'h0000, 2'd1, 1'b0, 5'b00_000, 3'b000}, // R5 switch to set1
    '{1'b1, 1'b0, 16'h0000, 2'd1, 1'b0, 5'b00_000, 3'b000},
    '{1'b1, 1'b0, 16'h0000, 2'd2, 1'b0, 5'b00_000, 3'b000},
    '{1'b1, 1'b1, 16'h1234, 2'd1, 1'b0, 5'b00_000, 3'b000}, // R2 load beats enable
    '{1'b1, 1'b0, 16'h0000, 2'd1, 1'b0, 5'b00_000, 3'b000},
    '{1'b0, 1'b1, 16'h0000, 2'd0, 1'b0, 5'b00_000, 3'b000}, // R2 zero seed
    '{1'b1, 1'b0, 16'h0000, 2'd3, 1'b0, 5'b00_000, 3'b000},
    '{1'b1, 1'b0, 16'h0000, 2'd0, 1'b1, 5'b00_000, 3'b111}, // R6 write while enabled
    '{1'b1, 1'b0, 16'h0000, 2'd0, 1'b0, 5'b00_000, 3'b000},
    '{1'b0, 1'b0, 16'h0000, 2'd2, 1'b0, 5'b00_000, 3'b000}, // R5 hold
    '{1'b1, 1'b0, 16'h0000, 2'd2, 1'b0, 5'b00_000, 3'b000},
    '{1'b1, 1'b0, 16'h0000, 2'd1, 1'b0, 5'b00_000, 3'b000}
  };

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int ones0, ones4;
    mLfsr = 16'hACE1; mPat = '0;
    for (int k = 0; k < 32; k++) mTbl[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    check("R7 reset pattern", patOut, 8'h00);
    // R7: default table passes single bits of the advanced state
    cyc(1, 0, 0, 2'd3, 0, 0, 0);
    check("R7 default weights", patOut, stepF(16'hACE1) & 8'hFF);
    check("R1 model state", patOut, mPat);

    for (int v = 0; v < NV; v++) begin
      cyc(VEC[v].en, VEC[v].ld, VEC[v].sd, VEC[v].sel, VEC[v].wr, VEC[v].ad, VEC[v].dt);
      check($sformatf("R1/R3/R5 vector %0d", v), patOut, mPat);
    end

    // R8 / R3 / R4: program set3, count ones over 2048 patterns
    for (int i = 0; i < 8; i++)
      cyc(0, 0, 0, 2'd0, 1, {2'd3, 3'(i)}, (i < 4) ? 3'b011 : 3'b111);
    check("R2 hold across idle writes", patOut, mPat);
    ones0 = 0; ones4 = 0;
    for (int n = 0; n < 2048; n++) begin
      cyc(1, 0, 0, 2'd3, 0, 0, 0);
      check("R3/R4 weighted run", patOut, mPat);
      ones0 += int'(patOut[0]);
      ones4 += int'(patOut[4]);
    end
    checks++;
    if (ones0 < 64 || ones0 > 200) begin
      fails++;
      $display("FAIL R8: depth3 one-count=%0d expected 64..200", ones0);
    end
    checks++;
    if (ones4 < 1840 || ones4 > 1990) begin
      fails++;
      $display("FAIL R8: complemented one-count=%0d expected 1840..1990", ones4);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule